// File: doc/BRIEF.md
# Lockable Watchdog Countdown Timer

This block is a 32-bit down-counter for a single core that serves either as a general-purpose interval timer or as a watchdog. In timer mode it counts down from a programmed value. On reaching zero it raises a raw status flag and, if enabled, an interrupt. It can reload itself and run again.

In watchdog mode, expiry produces a one-cycle reset request and a sticky reset flag, and the counter stops. No interrupt is raised. Once the watchdog mode bit is set, software cannot clear it through the control register. The only way out is a fixed two-word sequence written to a dedicated write-only disarm register. While the watchdog mode bit is set, direct writes to the counter are ignored, so a runaway program cannot hold the watchdog off by rewriting the count.

Software uses a simple write port and a separate combinational read port. Register offsets: 0x20 reload value, 0x24 live count, 0x28 control, 0x2C interrupt status, 0x30 reset status, 0x34 disarm.

Top module: `wdog_unlock_timer`

## Requirements
- R1: After reset every readable register reads 0, and `irq` and `rst_req` are low.
- R2: When the timer is enabled (control bit 0) and restarted with a count N≥1, the raw flag (bit 0 at 0x2C) sets exactly N·16^p cycles after the restarting clock edge. With auto-reload off, the counter then reads 0 and stays there.
- R3: Each of the following restarts the count and the step timer: a write to 0x20, which stores the reload value and loads the counter with it; a write to 0x24 in timer mode, which loads the counter; and a control write that changes bit 0 from 0 to 1, which reloads the counter from the stored reload value.
- R4: Control bits [9:8] hold the prescale p. Each count step lasts 16^p clock cycles.
- R5: With control bit 1 (auto-reload) set in timer mode, expiry reloads the counter from the reload value, and the timer expires again after another N steps.
- R6: With control bit 2 set, `irq` rises at a timer-mode expiry. Any write to 0x2C clears both the raw flag and `irq`.
- R7: While control bit 3 (watchdog mode) is set, a write to 0x24 leaves the counter unchanged.
- R8: An expiry in watchdog mode pulses `rst_req` high for exactly one cycle and sets bit 0 at 0x30. The counter stops at 0. Neither the raw flag nor `irq` is set.
- R9: A control write that has bit 3 clear leaves bit 3 set if it was already set. The other control fields still take the written values.
- R10: Any write to 0x30 clears the reset flag.
- R11: Bit 3 is cleared only by two consecutive writes to 0x34: 0x12345678, then 0x87654321. Any other write to 0x34 in between breaks the sequence.
- R12: Reading 0x34 returns 0, and `rst_req` never pulses in timer mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe, one write per cycle |
| wr_addr | input | 6 | Write byte offset |
| wr_data | input | 32 | Write data |
| rd_addr | input | 6 | Read byte offset |
| rd_data | output | 32 | Combinational read data |
| irq | output | 1 | Timer-mode interrupt (level) |
| rst_req | output | 1 | One-cycle reset request on watchdog expiry |

## Verification
The properties assume at most one register write per cycle, and that reset is held for at least one clock before normal operation. The write-only and sticky checks also assume that every write address is one of the six decoded offsets. The stimulus drives writes from a single task, one per cycle, to those offsets only. It brings the design back to a known state with a reset before each sequence, so the expected expiry cycles follow directly from the programmed count and prescale.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
    localparam int DATA_W  = 32;
    localparam int ADDR_W  = 6;
    localparam int PRESC_W = 2;
    // longest step is 16^(2^PRESC_W - 1) cycles
    localparam int TICK_W  = 4 * ((1 << PRESC_W) - 1);

    localparam logic [ADDR_W-1:0] OFF_LOAD  = 6'h20;
    localparam logic [ADDR_W-1:0] OFF_CNT   = 6'h24;
    localparam logic [ADDR_W-1:0] OFF_CTRL  = 6'h28;
    localparam logic [ADDR_W-1:0] OFF_ISTAT = 6'h2C;
    localparam logic [ADDR_W-1:0] OFF_RSTAT = 6'h30;
    localparam logic [ADDR_W-1:0] OFF_DIS   = 6'h34;

    localparam logic [DATA_W-1:0] KEY_FIRST  = 32'h1234_5678;
    localparam logic [DATA_W-1:0] KEY_SECOND = 32'h8765_4321;

    typedef struct packed {
        logic [PRESC_W-1:0] presc;
        logic               wd_mode;
        logic               irq_en;
        logic               auto_rl;
        logic               enable;
    } ctrl_t;

    function automatic ctrl_t ctrl_unpack(logic [DATA_W-1:0] w);
        ctrl_t c;
        c.enable  = w[0];
        c.auto_rl = w[1];
        c.irq_en  = w[2];
        c.wd_mode = w[3];
        c.presc   = w[8 +: PRESC_W];
        return c;
    endfunction

    function automatic logic [DATA_W-1:0] ctrl_pack(ctrl_t c);
        logic [DATA_W-1:0] w;
        w = '0;
        w[0] = c.enable;
        w[1] = c.auto_rl;
        w[2] = c.irq_en;
        w[3] = c.wd_mode;
        w[8 +: PRESC_W] = c.presc;
        return w;
    endfunction

    // last prescale count before a step completes: 16^p - 1
    function automatic logic [TICK_W-1:0] step_limit(logic [PRESC_W-1:0] p);
        logic [TICK_W:0] full;
        full = {{TICK_W{1'b0}}, 1'b1} << (4 * int'(p));
        return full[TICK_W-1:0] - 1'b1;
    endfunction
endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler
    import wdt_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               restart,
    input  logic               run,
    input  logic [PRESC_W-1:0] presc,
    output logic               tick
);
    logic [TICK_W-1:0] div_q;
    logic [TICK_W-1:0] lim;

    assign lim  = step_limit(presc);
    assign tick = run && !restart && (div_q == lim);

    always_ff @(posedge clk) begin
        if (rst || restart || !run || tick)
            div_q <= '0;
        else
            div_q <= div_q + 1'b1;
    end
endmodule

// File: rtl/wdt_countdown.sv
module wdt_countdown
    import wdt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              restart,
    input  logic [DATA_W-1:0] restart_val,
    input  logic              tick,
    input  logic              reload_en,
    input  logic [DATA_W-1:0] reload_val,
    output logic [DATA_W-1:0] count,
    output logic              expire,
    output logic              halted
);
    assign expire = tick && (count <= DATA_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            count  <= '0;
            halted <= 1'b0;
        end else if (restart) begin
            count  <= restart_val;
            halted <= 1'b0;
        end else if (expire) begin
            count  <= reload_en ? reload_val : '0;
            halted <= !reload_en;
        end else if (tick) begin
            count  <= count - 1'b1;
        end
    end
endmodule

// File: rtl/wdt_unlock.sv
module wdt_unlock
    import wdt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    output logic              hit
);
    logic [DATA_W-1:0] last_q;

    assign hit = wr && (last_q == KEY_FIRST) && (wdata == KEY_SECOND);

    always_ff @(posedge clk) begin
        if (rst)
            last_q <= '0;
        else if (wr)
            last_q <= wdata;
    end
endmodule

// File: rtl/wdog_unlock_timer.sv
module wdog_unlock_timer
    import wdt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              irq,
    output logic              rst_req
);
    ctrl_t             ctrl_q, ctrl_next;
    logic [DATA_W-1:0] load_q;
    logic              raw_q, pend_q, rflag_q, rreq_q;

    logic wr_load, wr_cnt, wr_ctrl, wr_istat, wr_rstat, wr_dis;
    logic en_rise, restart, run, tick, expire, halted, unlock_hit;
    logic exp_timer, exp_wd;
    logic [DATA_W-1:0] restart_val, count;

    assign wr_load  = wr_en && (wr_addr == OFF_LOAD);
    assign wr_cnt   = wr_en && (wr_addr == OFF_CNT);
    assign wr_ctrl  = wr_en && (wr_addr == OFF_CTRL);
    assign wr_istat = wr_en && (wr_addr == OFF_ISTAT);
    assign wr_rstat = wr_en && (wr_addr == OFF_RSTAT);
    assign wr_dis   = wr_en && (wr_addr == OFF_DIS);

    // watchdog mode may be set by a control write, never cleared by one
    always_comb begin
        ctrl_next = ctrl_unpack(wr_data);
        ctrl_next.wd_mode = ctrl_next.wd_mode | ctrl_q.wd_mode;
    end

    assign en_rise     = wr_ctrl && !ctrl_q.enable && ctrl_next.enable;
    assign restart     = wr_load || (wr_cnt && !ctrl_q.wd_mode) || en_rise;
    assign restart_val = en_rise ? load_q : wr_data;
    assign run         = ctrl_q.enable && !halted;
    assign exp_timer   = expire && !ctrl_q.wd_mode;
    assign exp_wd      = expire && ctrl_q.wd_mode;

    wdt_prescaler u_presc (
        .clk     (clk),
        .rst     (rst),
        .restart (restart),
        .run     (run),
        .presc   (ctrl_q.presc),
        .tick    (tick)
    );

    wdt_countdown u_count (
        .clk         (clk),
        .rst         (rst),
        .restart     (restart),
        .restart_val (restart_val),
        .tick        (tick),
        .reload_en   (ctrl_q.auto_rl && !ctrl_q.wd_mode),
        .reload_val  (load_q),
        .count       (count),
        .expire      (expire),
        .halted      (halted)
    );

    wdt_unlock u_unlock (
        .clk   (clk),
        .rst   (rst),
        .wr    (wr_dis),
        .wdata (wr_data),
        .hit   (unlock_hit)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q  <= '0;
            load_q  <= '0;
            raw_q   <= 1'b0;
            pend_q  <= 1'b0;
            rflag_q <= 1'b0;
            rreq_q  <= 1'b0;
        end else begin
            if (wr_ctrl)
                ctrl_q <= ctrl_next;
            else if (unlock_hit)
                ctrl_q.wd_mode <= 1'b0;

            if (wr_load)
                load_q <= wr_data;

            // a same-cycle expiry wins over a clearing write
            if (exp_timer)
                raw_q <= 1'b1;
            else if (wr_istat)
                raw_q <= 1'b0;

            if (exp_timer && ctrl_q.irq_en)
                pend_q <= 1'b1;
            else if (wr_istat)
                pend_q <= 1'b0;

            if (exp_wd)
                rflag_q <= 1'b1;
            else if (wr_rstat)
                rflag_q <= 1'b0;

            rreq_q <= exp_wd;
        end
    end

    always_comb begin
        unique case (rd_addr)
            OFF_LOAD:  rd_data = load_q;
            OFF_CNT:   rd_data = count;
            OFF_CTRL:  rd_data = ctrl_pack(ctrl_q);
            OFF_ISTAT: rd_data = {{(DATA_W-1){1'b0}}, raw_q};
            OFF_RSTAT: rd_data = {{(DATA_W-1){1'b0}}, rflag_q};
            default:   rd_data = '0;
        endcase
    end

    assign irq     = pend_q;
    assign rst_req = rreq_q;
endmodule

// File: rtl/wdt_checker.sv
module wdt_checker
    import wdt_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic              irq,
    input logic              rst_req,
    input logic              rflag,
    input logic              wd_mode,
    input logic              unlock_hit,
    input logic              tick,
    input logic              expire,
    input logic [DATA_W-1:0] count
);
    assert_rstreq_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        rst_req |=> !rst_req);

    assert_rstreq_flag_R8: assert property (@(posedge clk) disable iff (rst)
        rst_req |-> rflag);

    assert_wd_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        $fell(wd_mode) |-> $past(unlock_hit));

    assert_irq_clear_R6: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == OFF_ISTAT && !expire) |=> !irq);

    assert_count_locked_R7: assert property (@(posedge clk) disable iff (rst)
        (wd_mode && wr_en && wr_addr == OFF_CNT && !tick) |=> $stable(count));
endmodule

bind wdog_unlock_timer wdt_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .irq        (irq),
    .rst_req    (rst_req),
    .rflag      (rflag_q),
    .wd_mode    (ctrl_q.wd_mode),
    .unlock_hit (unlock_hit),
    .tick       (tick),
    .expire     (expire),
    .count      (count)
);

// File: tb/wdog_unlock_timer_tb_top.sv
`timescale 1ns/1ps
module wdog_unlock_timer_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [5:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [5:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        irq, rst_req;

    int n_chk = 0, n_bad = 0, pulses = 0;
    bit done = 0;

    always #2 clk = ~clk;   // 250 MHz

    wdog_unlock_timer dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .irq(irq), .rst_req(rst_req)
    );

    always @(negedge clk) if (!rst && rst_req) pulses++;

    function automatic int step_cycles(int p);
        return 16 ** p;
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [5:0] a, logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(logic [5:0] a, output logic [31:0] d);
        rd_addr = a;
        #0.5;
        d = rd_data;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic wait_cyc(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        #800000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: run did not finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] v;
        void'($urandom(32'd1234));
        do_reset();

        // R1: reset values
        for (int a = 8; a < 14; a++) begin
            rd(6'(a * 4), v);
            chk("R1 reg", v, 32'h0);
        end
        chk("R1 irq", {31'b0, irq}, 0);
        chk("R1 rst_req", {31'b0, rst_req}, 0);

        // R2 R4 R6: random count/prescale, single shot
        for (int it = 0; it < 10; it++) begin
            int n, p, s;
            n = 1 + int'($urandom % 12);
            p = int'($urandom % 2);
            s = n * step_cycles(p);
            do_reset();
            wr(6'h20, 32'(n));
            rd(6'h24, v);
            chk("R3 load sets counter", v, 32'(n));
            wr(6'h28, 32'h4 | 32'h1 | 32'(p << 8));
            wait_cyc(s - 1);
            rd(6'h2C, v);
            chk("R2 R4 raw before expiry", v, 0);
            chk("R6 irq before expiry", {31'b0, irq}, 0);
            wait_cyc(1);
            rd(6'h2C, v);
            chk("R2 R4 raw at expiry", v, 1);
            chk("R6 irq at expiry", {31'b0, irq}, 1);
            wait_cyc(3);
            rd(6'h24, v);
            chk("R2 counter stays 0", v, 0);
        end

        // R5 R6: auto reload, clear, second expiry
        do_reset();
        wr(6'h20, 32'd5);
        wr(6'h28, 32'h7);
        wait_cyc(4);
        rd(6'h2C, v); chk("R5 raw before", v, 0);
        wait_cyc(1);
        rd(6'h2C, v); chk("R5 raw first", v, 1);
        rd(6'h24, v); chk("R5 reloaded", v, 5);
        wr(6'h2C, 32'h0);
        rd(6'h2C, v); chk("R6 raw cleared", v, 0);
        chk("R6 irq cleared", {31'b0, irq}, 0);
        wait_cyc(3);
        rd(6'h2C, v); chk("R5 raw before second", v, 0);
        wait_cyc(1);
        rd(6'h2C, v); chk("R5 raw second", v, 1);

        // R3: counter write restarts in timer mode
        do_reset();
        wr(6'h20, 32'd50);
        wr(6'h28, 32'h1);
        wr(6'h24, 32'd4);
        wait_cyc(3);
        rd(6'h2C, v); chk("R3 raw before", v, 0);
        wait_cyc(1);
        rd(6'h2C, v); chk("R3 raw after counter write", v, 1);
        chk("R12 no rst_req in timer mode", 32'(pulses), 0);

        // R7 R8: watchdog mode, prescale 1
        do_reset();
        wr(6'h20, 32'd3);
        wr(6'h28, 32'h10D);
        wr(6'h24, 32'd100);
        rd(6'h24, v); chk("R7 counter write ignored", v, 3);
        wait_cyc(3 * 16 - 2);
        chk("R8 rst_req before", {31'b0, rst_req}, 0);
        wait_cyc(1);
        chk("R8 rst_req pulse", {31'b0, rst_req}, 1);
        rd(6'h30, v); chk("R8 reset flag", v, 1);
        wait_cyc(1);
        chk("R8 rst_req one cycle", {31'b0, rst_req}, 0);
        wait_cyc(40);
        rd(6'h24, v); chk("R8 counter stopped", v, 0);
        rd(6'h2C, v); chk("R8 raw not set", v, 0);
        chk("R8 no irq", {31'b0, irq}, 0);
        chk("R8 single pulse", 32'(pulses), 1);

        // R9: control write cannot clear watchdog bit
        wr(6'h28, 32'h1);
        rd(6'h28, v); chk("R9 wd bit sticky", v, 32'h9);

        // R10: clear reset flag
        wr(6'h30, 32'h0);
        rd(6'h30, v); chk("R10 flag cleared", v, 0);

        // R11 R12: unlock sequence
        wr(6'h34, 32'h8765_4321);
        rd(6'h28, v); chk("R11 second key alone", v[3], 1);
        wr(6'h34, 32'h1234_5678);
        wr(6'h34, 32'h0);
        wr(6'h34, 32'h8765_4321);
        rd(6'h28, v); chk("R11 broken sequence", v[3], 1);
        rd(6'h34, v); chk("R12 disarm reads 0", v, 0);
        wr(6'h34, 32'h1234_5678);
        wr(6'h34, 32'h8765_4321);
        rd(6'h28, v); chk("R11 unlocked", v[3], 0);
        wr(6'h24, 32'd7);
        rd(6'h24, v); chk("R7 counter writable after unlock", v, 7);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule